// File: doc/BRIEF.md
# Processor Wake-Up Message Sequencer

This block brings a sleeping application processor (or every processor except the sender) out of reset. A single start request triggers three interrupt messages in a fixed order: a reset-style INIT message, then a start-up message, then the same start-up message again. The block drives the two 32-bit words of an interrupt-command register. For every message it writes the destination word first and the command word second. Writing the command word launches the message.

After each launch, the block polls the delivery-status bit that the message fabric returns. It moves on only when that bit reads clear. Between the messages it inserts two settling delays, 10 us and 200 us. These delays are counted in clock cycles from a clock-frequency parameter.

The start-up address must be page aligned and must lie in the first megabyte. The target ID must fit in eight bits. A request that breaks either rule raises an error pulse and sends nothing.

Top module: `ipi_wake_seq`

## Requirements
- R1: After reset the block is idle: `busy_o`, `done_o`, `err_o` and `reg_we_o` are all low.
- R2: A start request whose address is 0x100000 or above, or whose low 12 bits are not all zero, causes no register write. It raises `err_o` for exactly one cycle, in the cycle after the request, and the block returns to idle.
- R3: In unicast mode a target ID above 0xFF is rejected in the same way as R2. In broadcast mode the target ID input is ignored.
- R4: Each message is two consecutive write cycles. The first write has `reg_sel_hi_o`=1 and data with the destination ID in bits 31:24 and zeros elsewhere. The second write has `reg_sel_hi_o`=0 and carries the command word.
- R5: The first message's command word has delivery mode 3'b101 in bits 10:8, the level bit (bit 14) set, vector bits 7:0 zero, and all other bits zero except the shorthand of R10.
- R6: After a command-word write, no further write happens while `dlv_busy_i` is high. The block leaves polling in the cycle after it samples `dlv_busy_i` low.
- R7: After the INIT message is accepted, the block waits exactly CLK_MHZ*INIT_US cycles before the next destination write. Measured from the INIT command write to the next destination write, this is L+3+CLK_MHZ*INIT_US cycles, where L is the number of extra cycles the fabric holds status high.
- R8: The start-up command word has delivery mode 3'b110 in bits 10:8, the level bit 14 set, and bits 7:0 equal to bits 19:12 of the start-up address.
- R9: After the first start-up message is accepted, the block waits CLK_MHZ*SU_US cycles and then sends an identical second start-up message. The timing formula of R7 applies with SU_US in place of INIT_US.
- R10: In broadcast mode every command word has bits 19:18 = 2'b11 (all except self) and every destination word is zero. In unicast mode bits 19:18 are 2'b00.
- R11: `done_o` pulses for one cycle, in the cycle after the block samples status clear following the second start-up message. `busy_o` is high from the cycle after an accepted request through the last polling cycle, and is never high together with `done_o`.
- R12: A start request is acted on only while the block is idle. A request held during a sequence, including during the `done_o` cycle, produces no extra writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to run a wake-up sequence |
| target_i | input | TGT_W | Target processor ID |
| bcast_i | input | 1 | Address all processors except self |
| su_addr_i | input | ADDR_W | Start-up code address |
| dlv_busy_i | input | 1 | Delivery-status bit read back from the command register |
| reg_we_o | output | 1 | Command register write strobe |
| reg_sel_hi_o | output | 1 | 1 selects the destination word, 0 the command word |
| reg_wdata_o | output | 32 | Write data |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle illegal-request pulse |

## Verification
The critical overlap is a start request that coincides with the end of a sequence: the same cycle in which `done_o` pulses and the block returns to idle. The bench provokes this by holding `start_i` high from the launching request through the `done_o` cycle, while the fabric model stretches delivery status by a few cycles. A behavioural model of the protocol is compared with every output on every clock, and the logged writes must then contain exactly six words. Any restart on the done cycle would add a seventh write and break both checks.

// File: rtl/ipi_seq_pkg.sv
package ipi_seq_pkg;

   typedef enum logic [2:0] {
      S_IDLE, S_HI, S_LO, S_POLL, S_WAIT, S_DONE, S_ERR
   } seq_state_t;

   typedef enum logic [1:0] {
      M_INIT, M_SU1, M_SU2
   } msg_t;

   localparam logic [2:0] DM_INIT    = 3'b101;
   localparam logic [2:0] DM_STARTUP = 3'b110;
   localparam logic [1:0] SH_NONE    = 2'b00;
   localparam logic [1:0] SH_OTHERS  = 2'b11;

   localparam int DM_LSB   = 8;
   localparam int LVL_BIT  = 14;
   localparam int SH_LSB   = 18;
   localparam int DEST_LSB = 24;

   function automatic logic [31:0] pack_cmd(input logic [2:0] dm,
                                            input logic [7:0] vec,
                                            input logic       others);
      logic [31:0] w;
      w = '0;
      w[7:0]              = vec;
      w[DM_LSB +: 3]      = dm;
      w[LVL_BIT]          = 1'b1;
      w[SH_LSB +: 2]      = others ? SH_OTHERS : SH_NONE;
      return w;
   endfunction

endpackage

// File: rtl/ipi_req_check.sv
module ipi_req_check #(
   parameter int TGT_W      = 32,
   parameter int ADDR_W     = 32,
   parameter int DEST_W     = 8,
   parameter int ALIGN_BITS = 12,
   parameter int LIMIT_BITS = 20
) (
   input  logic [TGT_W-1:0]  tgt_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              bcast_i,
   output logic              ok_o,
   output logic [7:0]        vec_o,
   output logic [DEST_W-1:0] dest_o
);
   localparam int KEEP_W = (TGT_W < DEST_W) ? TGT_W : DEST_W;

   logic id_fits;
   logic addr_low;
   logic addr_aligned;

   initial begin
      assert (ADDR_W >= LIMIT_BITS && LIMIT_BITS >= ALIGN_BITS + 8)
         else $error("address parameters inconsistent");
   end

   generate
      if (TGT_W > DEST_W) begin : g_wide_id
         assign id_fits = (tgt_i[TGT_W-1:DEST_W] == '0);
      end else begin : g_narrow_id
         assign id_fits = 1'b1;
      end

      if (ADDR_W > LIMIT_BITS) begin : g_wide_addr
         assign addr_low = (addr_i[ADDR_W-1:LIMIT_BITS] == '0);
      end else begin : g_exact_addr
         assign addr_low = 1'b1;
      end
   endgenerate

   assign addr_aligned = (addr_i[ALIGN_BITS-1:0] == '0);
   assign ok_o   = addr_low && addr_aligned && (bcast_i || id_fits);
   assign vec_o  = addr_i[ALIGN_BITS +: 8];

   always_comb begin
      dest_o = '0;
      if (!bcast_i) dest_o[KEEP_W-1:0] = tgt_i[KEEP_W-1:0];
   end
endmodule

// File: rtl/ipi_delay_timer.sv
module ipi_delay_timer #(
   parameter int CNT_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic             expired_o
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)            cnt_q <= '0;
      else if (load_i)       cnt_q <= load_val_i;
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/ipi_cmd_fmt.sv
module ipi_cmd_fmt
   import ipi_seq_pkg::*;
#(
   parameter int DEST_W = 8
) (
   input  msg_t              msg_i,
   input  logic [7:0]        vec_i,
   input  logic [DEST_W-1:0] dest_i,
   input  logic              bcast_i,
   output logic [31:0]       hi_o,
   output logic [31:0]       lo_o
);
   always_comb begin
      hi_o = '0;
      hi_o[DEST_LSB +: DEST_W] = dest_i;
      if (msg_i == M_INIT) lo_o = pack_cmd(DM_INIT, 8'h00, bcast_i);
      else                 lo_o = pack_cmd(DM_STARTUP, vec_i, bcast_i);
   end
endmodule

// File: rtl/ipi_wake_seq.sv
module ipi_wake_seq
   import ipi_seq_pkg::*;
#(
   parameter int CLK_MHZ = 50,
   parameter int INIT_US = 10,
   parameter int SU_US   = 200,
   parameter int TGT_W   = 32,
   parameter int ADDR_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [TGT_W-1:0]  target_i,
   input  logic              bcast_i,
   input  logic [ADDR_W-1:0] su_addr_i,
   input  logic              dlv_busy_i,
   output logic              reg_we_o,
   output logic              reg_sel_hi_o,
   output logic [31:0]       reg_wdata_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              err_o
);
   localparam int DEST_W   = 8;
   localparam int INIT_CYC = CLK_MHZ * INIT_US;
   localparam int SU_CYC   = CLK_MHZ * SU_US;
   localparam int MAX_CYC  = (INIT_CYC > SU_CYC) ? INIT_CYC : SU_CYC;
   localparam int CNT_W    = $clog2(MAX_CYC + 1);
   localparam logic [CNT_W-1:0] INIT_LD = CNT_W'(INIT_CYC - 1);
   localparam logic [CNT_W-1:0] SU_LD   = CNT_W'(SU_CYC - 1);

   initial begin
      assert (CLK_MHZ > 0 && INIT_US > 0 && SU_US > 0)
         else $error("delays must be at least one cycle");
   end

   seq_state_t        state_q;
   msg_t              msg_q;
   logic [7:0]        vec_q;
   logic [DEST_W-1:0] dest_q;
   logic              bc_q;

   logic              req_ok;
   logic [7:0]        req_vec;
   logic [DEST_W-1:0] req_dest;
   logic              tmr_load;
   logic [CNT_W-1:0]  tmr_val;
   logic              tmr_expired;
   logic [31:0]       hi_word;
   logic [31:0]       lo_word;

   ipi_req_check #(
      .TGT_W(TGT_W), .ADDR_W(ADDR_W), .DEST_W(DEST_W),
      .ALIGN_BITS(12), .LIMIT_BITS(20)
   ) u_check (
      .tgt_i(target_i), .addr_i(su_addr_i), .bcast_i(bcast_i),
      .ok_o(req_ok), .vec_o(req_vec), .dest_o(req_dest)
   );

   ipi_delay_timer #(.CNT_W(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .load_i(tmr_load),
      .load_val_i(tmr_val), .expired_o(tmr_expired)
   );

   ipi_cmd_fmt #(.DEST_W(DEST_W)) u_fmt (
      .msg_i(msg_q), .vec_i(vec_q), .dest_i(dest_q), .bcast_i(bc_q),
      .hi_o(hi_word), .lo_o(lo_word)
   );

   assign tmr_load = (state_q == S_POLL) && !dlv_busy_i && (msg_q != M_SU2);
   assign tmr_val  = (msg_q == M_INIT) ? INIT_LD : SU_LD;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         msg_q   <= M_INIT;
         vec_q   <= '0;
         dest_q  <= '0;
         bc_q    <= 1'b0;
      end else begin
         case (state_q)
            S_IDLE: if (start_i) begin
               if (req_ok) begin
                  state_q <= S_HI;
                  msg_q   <= M_INIT;
                  vec_q   <= req_vec;
                  dest_q  <= req_dest;
                  bc_q    <= bcast_i;
               end else begin
                  state_q <= S_ERR;
               end
            end
            S_HI:   state_q <= S_LO;
            S_LO:   state_q <= S_POLL;
            S_POLL: if (!dlv_busy_i) begin
               state_q <= (msg_q == M_SU2) ? S_DONE : S_WAIT;
            end
            S_WAIT: if (tmr_expired) begin
               state_q <= S_HI;
               msg_q   <= (msg_q == M_INIT) ? M_SU1 : M_SU2;
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   assign reg_we_o     = (state_q == S_HI) || (state_q == S_LO);
   assign reg_sel_hi_o = (state_q == S_HI);
   assign reg_wdata_o  = (state_q == S_HI) ? hi_word :
                         (state_q == S_LO) ? lo_word : 32'h0;
   assign busy_o = (state_q != S_IDLE) && (state_q != S_DONE) && (state_q != S_ERR);
   assign done_o = (state_q == S_DONE);
   assign err_o  = (state_q == S_ERR);

   // R4: a command-word write is always preceded by a destination write
   a_r4_lo_follows_hi: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we_o && !reg_sel_hi_o) |-> $past(reg_we_o && reg_sel_hi_o));

   // R4 / R10: destination word carries nothing below the ID field
   a_r4_hi_clean: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we_o && reg_sel_hi_o) |-> (reg_wdata_o[23:0] == 24'h0));

   // R6: status still pending keeps the block polling with no write
   a_r6_poll_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_POLL && dlv_busy_i) |=> (state_q == S_POLL && !reg_we_o));

   // R11: done is a single-cycle pulse, exclusive with busy
   a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   a_r11_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && busy_o));

   // R2: an error cycle follows an idle cycle and writes nothing
   a_r2_err_clean: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> (!reg_we_o && $past(state_q == S_IDLE && start_i)));

   // R10: broadcast uses the all-but-self shorthand on every command word
   a_r10_shorthand: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we_o && !reg_sel_hi_o && bc_q) |-> (reg_wdata_o[19:18] == 2'b11));
endmodule

// File: tb/ipi_wake_seq_tb.sv
module ipi_wake_seq_tb;
   localparam int CLK_MHZ = 50;
   localparam int N_INIT  = CLK_MHZ * 10;
   localparam int N_SU    = CLK_MHZ * 200;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [31:0] target_i = '0;
   logic        bcast_i = 1'b0;
   logic [31:0] su_addr_i = '0;
   logic        pend = 1'b0;
   logic        reg_we_o, reg_sel_hi_o, busy_o, done_o, err_o;
   logic [31:0] reg_wdata_o;

   int n_chk = 0, n_fail = 0, cyc = 0, lat = 0, lcnt = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   ipi_wake_seq #(.CLK_MHZ(CLK_MHZ)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .target_i(target_i),
      .bcast_i(bcast_i), .su_addr_i(su_addr_i), .dlv_busy_i(pend),
      .reg_we_o(reg_we_o), .reg_sel_hi_o(reg_sel_hi_o),
      .reg_wdata_o(reg_wdata_o), .busy_o(busy_o), .done_o(done_o),
      .err_o(err_o)
   );

   task automatic chk(input bit ok, input string tag,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   // message fabric: status set by a command write, cleared after lat cycles
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (!rst_n) pend <= 1'b0;
      else if (reg_we_o && !reg_sel_hi_o) begin pend <= 1'b1; lcnt <= lat; end
      else if (pend) begin
         if (lcnt == 0) pend <= 1'b0;
         else lcnt <= lcnt - 1;
      end
   end

   // write log
   logic [32:0] wlog[$];
   int          wcyc[$];
   always @(posedge clk) if (rst_n && reg_we_o) begin
      wlog.push_back({reg_sel_hi_o, reg_wdata_o});
      wcyc.push_back(cyc);
   end

   function automatic bit legal(input logic [31:0] id, input logic [31:0] a, input bit bc);
      return (a < 32'h100000) && (a % 4096 == 0) && (bc || id <= 255);
   endfunction

   function automatic logic [31:0] cmd_word(input int dm, input logic [31:0] a, input bit bc);
      return (dm << 8) | (1 << 14) | (bc ? (3 << 18) : 0) | ((dm == 6) ? (a >> 12) : 0);
   endfunction

   // behavioural protocol model: 0 idle,1 dest write,2 cmd write,3 poll,4 wait,5 done,6 err
   int ph = 0, m = 0, wc = 0;
   logic [31:0] m_id, m_addr;
   bit m_bc;
   always @(posedge clk) begin
      if (!rst_n) ph <= 0;
      else case (ph)
         0: if (start_i) begin
               if (legal(target_i, su_addr_i, bcast_i)) begin
                  ph <= 1; m <= 0; m_id <= target_i; m_addr <= su_addr_i; m_bc <= bcast_i;
               end else ph <= 6;
            end
         1: ph <= 2;
         2: ph <= 3;
         3: if (!pend) begin
               if (m == 2) ph <= 5;
               else begin ph <= 4; wc <= (m == 0) ? N_INIT : N_SU; end
            end
         4: begin
               if (wc == 1) begin ph <= 1; m <= m + 1; end
               wc <= wc - 1;
            end
         default: ph <= 0;
      endcase
   end

   // per-cycle comparison away from the active edge
   always @(negedge clk) if (rst_n && !finished) begin
      logic [35:0] e, a;
      logic [31:0] d;
      d = 0;
      if (ph == 1) d = m_bc ? 32'h0 : (m_id << 24);
      if (ph == 2) d = (m == 0) ? cmd_word(5, m_addr, m_bc) : cmd_word(6, m_addr, m_bc);
      e = {(ph == 1 || ph == 2), (ph == 1), (ph >= 1 && ph <= 4), (ph == 5), d};
      a = {reg_we_o, reg_sel_hi_o, busy_o, done_o, reg_wdata_o};
      a[35] = a[35] | err_o ^ (ph == 6);
      chk(a == e, (ph == 3) ? "R6 poll" : (ph == 4) ? "R7 wait" :
                  (ph == 5) ? "R11 done" : (ph == 6) ? "R2 error" : "R4 write",
          64'(a), 64'(e));
   end

   task automatic run(input logic [31:0] id, input logic [31:0] a, input bit bc,
                      input int l, input bit hold);
      bit saw_err = 0, saw_done = 0;
      int loops = 0;
      wlog.delete(); wcyc.delete();
      lat = l;
      @(negedge clk);
      target_i = id; su_addr_i = a; bcast_i = bc; start_i = 1'b1;
      @(negedge clk);
      if (!hold) start_i = 1'b0;
      if (err_o) saw_err = 1;
      while (!saw_err && !saw_done && loops < 20000) begin
         if (done_o) saw_done = 1;
         else begin @(negedge clk); loops++; if (err_o) saw_err = 1; end
      end
      if (hold) begin @(negedge clk); start_i = 1'b0; end
      repeat (5) @(negedge clk);
      if (!legal(id, a, bc)) begin
         chk(saw_err, bc ? "R2" : (a < 32'h100000 && a % 4096 == 0) ? "R3" : "R2",
             64'(saw_err), 1);
         chk(wlog.size() == 0, "R2 no write", 64'(wlog.size()), 0);
      end else begin
         logic [31:0] hi_e, ci, cs;
         hi_e = bc ? 0 : (id << 24);
         ci = cmd_word(5, a, bc); cs = cmd_word(6, a, bc);
         chk(saw_done, "R11", 64'(saw_done), 1);
         chk(wlog.size() == 6, hold ? "R12 write count" : "R4 write count",
             64'(wlog.size()), 6);
         if (wlog.size() == 6) begin
            chk(wlog[0] == {1'b1, hi_e}, bc ? "R10" : "R4", 64'(wlog[0]), 64'({1'b1, hi_e}));
            chk(wlog[1] == {1'b0, ci}, "R5", 64'(wlog[1]), 64'({1'b0, ci}));
            chk(wlog[3] == {1'b0, cs}, "R8", 64'(wlog[3]), 64'({1'b0, cs}));
            chk(wlog[5] == wlog[3] && wlog[4] == wlog[2], "R9 repeat",
                64'(wlog[5]), 64'(wlog[3]));
            chk(wcyc[2] - wcyc[1] == l + 3 + N_INIT, "R7 gap",
                64'(wcyc[2] - wcyc[1]), 64'(l + 3 + N_INIT));
            chk(wcyc[4] - wcyc[3] == l + 3 + N_SU, "R9 gap",
                64'(wcyc[4] - wcyc[3]), 64'(l + 3 + N_SU));
            chk(wcyc[1] - wcyc[0] == 1, "R4 order", 64'(wcyc[1] - wcyc[0]), 1);
         end
      end
   endtask

   initial begin
      repeat (4) @(negedge clk);
      chk({busy_o, done_o, err_o, reg_we_o} == 4'b0, "R1 during reset",
          64'({busy_o, done_o, err_o, reg_we_o}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk({busy_o, done_o, err_o, reg_we_o} == 4'b0, "R1 after reset",
          64'({busy_o, done_o, err_o, reg_we_o}), 0);
      run(32'h05, 32'h9A000, 1'b0, 0, 1'b0);       // unicast, immediate accept
      run(32'h00, 32'h00000, 1'b1, 3, 1'b1);       // R12: start held across done
      run(32'h01, 32'h100000, 1'b0, 0, 1'b0);      // R2 address too high
      run(32'h01, 32'h9A800, 1'b0, 0, 1'b0);       // R2 misaligned
      run(32'h100, 32'h10000, 1'b0, 0, 1'b0);      // R3 ID too wide
      run(32'h1FF, 32'hFF000, 1'b1, 1, 1'b0);      // R3 ID ignored in broadcast
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      wait (cyc > 190000);
      if (!finished) begin
         finished = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=%0d expected=<190000", cyc);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule